// File: doc/BRIEF.md
# Buffered Serial Caller-ID Data Port

This block sits between an asynchronous, already demodulated caller-ID bit line and a host microcontroller. A mode input picks one of two ways to hand the bits over. In pass-through mode the block copies the incoming line straight to its data output, and the host does its own bit timing. In buffered mode the block does the timing itself. It finds each start bit and samples every following bit at its centre, using a baud counter driven by the reference clock. It then keeps the eight data bits and the stop bit in a nine-bit buffer and drops the start bit.

When a word has been captured, an active-low ready strobe tells the host to fetch it. The host clocks the buffer out with pulses on its own clock input. Before each pulse the host reads one bit, least significant data bit first. The value read before the ninth pulse is the stop bit, which the host uses to check framing. A particular combination of the mode input and two control inputs puts the block into a power-down state.

Top module: `fsk_host_port`

## Requirements
- R1: When mode_sel is 0 and the block is not powered down, data_out equals rx_bit in the same cycle (combinational path). In this mode host_clk has no effect: it neither shortens the ready strobe nor shifts the buffer.
- R2: After reset, with mode_sel = 1 and ctl1 = 1, ready_n is 1 and data_out is 1, because the buffer resets to all ones.
- R3: A word begins only on a falling edge of the synchronised rx_bit that is still low half a bit time (CLKS_PER_BIT/2 cycles) later. A low pulse shorter than that starts no word and gives no ready strobe.
- R4: When a word completes, ready_n goes low for exactly CLKS_PER_BIT/2 clock cycles. In mode 1 it returns high early, at the first detected rising edge of host_clk. The strobe occurs in both modes.
- R5: In mode 1, after a word completes, data_out shows data bit 0. Each rising edge of host_clk advances data_out by one bit. The values read before pulses 1 to 8 are data bits 0 to 7 (data bits arrive LSB first). The value read before pulse 9 is the received stop bit, including a 0 stop bit. After nine pulses data_out is 1.
- R6: Power-down is mode_sel = 1 with ctl1 = 0 and ctl2 = 0. In power-down, data_out and ready_n are 1, reception stops, and the buffer is cleared to all ones. Leaving power-down therefore shows data_out = 1.
- R7: If a second word completes before the first has been read, the buffer holds the second word.
- R8: host_clk passes through a two-stage synchroniser. One pulse, however long, advances the buffer by exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = pass-through, 1 = buffered |
| ctl1 | input | 1 | Control input, used only in the power-down decode |
| ctl2 | input | 1 | Control input, used only in the power-down decode |
| rx_bit | input | 1 | Demodulated asynchronous bit line, idle high |
| host_clk | input | 1 | Host read clock, asynchronous |
| data_out | output | 1 | Serial data to the host |
| ready_n | output | 1 | Active-low word-ready strobe |

## Verification
The bench builds the block with CLKS_PER_BIT = 16 and DATA_BITS = 8. A whole frame then takes 160 cycles, so many words, back-to-back overwrites and power-down entries fit in a short run. With these values the half-bit window is 8 cycles. That is short enough to measure the ready strobe to the exact cycle, and to aim a glitch a few cycles shorter than the start-bit check point. The deployed default of roughly 2983 cycles per bit exercises the same counter logic, only with a wider count.

// File: rtl/fskp_pkg.sv
package fskp_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rx_state_e;

    // Reference clock of 3.579545 MHz at 1200 baud.
    localparam int DEFAULT_CLKS_PER_BIT = 2983;
    localparam int DEFAULT_DATA_BITS    = 8;

    function automatic logic is_power_down(input logic mode, input logic c1, input logic c2);
        return mode & ~c1 & ~c2;
    endfunction

endpackage

// File: rtl/fskp_sync.sv
module fskp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fskp_rx.sv
module fskp_rx
    import fskp_pkg::*;
#(
    parameter int CLKS_PER_BIT = DEFAULT_CLKS_PER_BIT,
    parameter int DATA_BITS    = DEFAULT_DATA_BITS
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 line,
    output logic                 done,
    output logic [DATA_BITS:0]   word
);
    localparam int FRAME = DATA_BITS + 1;
    localparam int HALF  = CLKS_PER_BIT / 2;
    localparam int CW    = $clog2(CLKS_PER_BIT + 1);
    localparam int IW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] HALF_M1  = CW'(HALF - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME - 1);

    rx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [IW-1:0]      idx;
    logic [FRAME-1:0]   shreg;
    logic               line_q;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            line_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            line_q <= line;
            done_q <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (line_q && !line) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == HALF_M1) begin
                        cnt <= '0;
                        idx <= '0;
                        state <= line ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt == BIT_LAST) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[FRAME-1:1]};
                        if (idx == IDX_LAST) begin
                            state  <= RX_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign word = shreg;

    AST_START_REJECT: assert property (@(posedge clk) disable iff (clr)
        (state == RX_START && cnt == HALF_M1 && line) |=> (state == RX_IDLE && !done_q)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (clr)
        done_q |=> !done_q); // R4
endmodule

// File: rtl/fskp_buf.sv
module fskp_buf #(
    parameter int HALF_BIT = 8,
    parameter int FRAME    = 9
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [FRAME-1:0] word,
    input  logic             shift_en,
    input  logic             hclk_s,
    output logic             data_bit,
    output logic             ready_n
);
    localparam int HW = $clog2(HALF_BIT + 1);

    logic             hs_q;
    logic [FRAME-1:0] sreg;
    logic [HW-1:0]    rcnt;
    logic             hedge;

    assign hedge = hclk_s & ~hs_q & shift_en;

    always_ff @(posedge clk) begin
        if (clr) begin
            hs_q <= 1'b0;
            sreg <= '1;
            rcnt <= '0;
        end else begin
            hs_q <= hclk_s;
            if (load) begin
                sreg <= word;
                rcnt <= HW'(HALF_BIT);
            end else if (hedge) begin
                sreg <= {1'b1, sreg[FRAME-1:1]};
                rcnt <= '0;
            end else if (rcnt != '0) begin
                rcnt <= rcnt - 1'b1;
            end
        end
    end

    assign data_bit = sreg[0];
    assign ready_n  = (rcnt == '0);

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (clr)
        load |=> !ready_n); // R4

    AST_EDGE_ENDS_READY: assert property (@(posedge clk) disable iff (clr)
        (hedge && !load) |=> ready_n); // R4

    AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (clr)
        (hedge && !load) |=> sreg[FRAME-1]); // R5

    AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (clr)
        (!shift_en && !load) |=> $stable(sreg)); // R1
endmodule

// File: rtl/fsk_host_port.sv
module fsk_host_port
    import fskp_pkg::*;
#(
    parameter int CLKS_PER_BIT = DEFAULT_CLKS_PER_BIT,
    parameter int DATA_BITS    = DEFAULT_DATA_BITS,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic ctl1,
    input  logic ctl2,
    input  logic rx_bit,
    input  logic host_clk,
    output logic data_out,
    output logic ready_n
);
    localparam int FRAME = DATA_BITS + 1;
    localparam int HALF  = CLKS_PER_BIT / 2;

    logic             pd;
    logic             clr;
    logic             rx_s;
    logic             hclk_s;
    logic             rx_done;
    logic [FRAME-1:0] rx_word;
    logic             buf_bit;
    logic             buf_ready_n;

    assign pd  = is_power_down(mode_sel, ctl1, ctl2);
    assign clr = rst | pd;

    fskp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rx_sync (
        .clk(clk), .rst(clr), .d(rx_bit), .q(rx_s)
    );

    fskp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_hclk_sync (
        .clk(clk), .rst(clr), .d(host_clk), .q(hclk_s)
    );

    fskp_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) i_rx (
        .clk(clk), .clr(clr), .line(rx_s), .done(rx_done), .word(rx_word)
    );

    fskp_buf #(.HALF_BIT(HALF), .FRAME(FRAME)) i_buf (
        .clk(clk), .clr(clr), .load(rx_done), .word(rx_word),
        .shift_en(mode_sel), .hclk_s(hclk_s),
        .data_bit(buf_bit), .ready_n(buf_ready_n)
    );

    assign data_out = pd ? 1'b1 : (mode_sel ? buf_bit : rx_bit);
    assign ready_n  = pd | buf_ready_n;

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        pd |=> (buf_bit && buf_ready_n && !rx_done)); // R6
endmodule

// File: tb/test_fsk_host_port.sv
module test_fsk_host_port;
    localparam int C    = 16;
    localparam int HALF = C / 2;
    localparam int FR   = 9;
    localparam int NV   = 6;
    // Frames as {stop, data[7:0]}.
    localparam logic [8:0] VEC [NV] = '{9'h1A5, 9'h100, 9'h1FF, 9'h13C, 9'h0C3, 9'h155};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b1, ctl1 = 1'b1, ctl2 = 1'b0;
    logic rx_bit = 1'b1, host_clk = 1'b0;
    logic data_out, ready_n;

    int checks = 0, fails = 0;
    int ready_events = 0, last_len = 0, cur_len = 0;

    always #2 clk = ~clk;

    fsk_host_port #(.CLKS_PER_BIT(C), .DATA_BITS(8)) i_fsk_host_port (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ctl1(ctl1), .ctl2(ctl2),
        .rx_bit(rx_bit), .host_clk(host_clk), .data_out(data_out), .ready_n(ready_n)
    );

    always @(negedge clk) begin
        if (rst) begin
            cur_len = 0;
        end else if (!ready_n) begin
            cur_len++;
        end else if (cur_len != 0) begin
            last_len = cur_len;
            ready_events++;
            cur_len = 0;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [8:0] f);
        @(negedge clk);
        rx_bit = 1'b0;
        repeat (C) @(negedge clk);
        for (int i = 0; i < FR; i++) begin
            rx_bit = f[i];
            repeat (C) @(negedge clk);
        end
        rx_bit = 1'b1;
        repeat (2 * C) @(negedge clk);
    endtask

    task automatic pulse(input int high_cycles);
        host_clk = 1'b1;
        repeat (high_cycles) @(negedge clk);
        host_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_bits(input int first, output logic [8:0] got);
        got = '1;
        for (int i = first; i < FR; i++) begin
            got[i] = data_out;
            pulse(4);
        end
    endtask

    task automatic pulse_on_ready();
        do @(negedge clk); while (ready_n);
        pulse(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] got;
        int ev;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk(ready_n == 1'b1, "R2 ready_n after reset", ready_n, 1);
        chk(data_out == 1'b1, "R2 data_out after reset", data_out, 1);

        // R4 R5: vector table in buffered mode
        for (int v = 0; v < NV; v++) begin
            ev = ready_events;
            send_frame(VEC[v]);
            chk(ready_events == ev + 1 && last_len == HALF, "R4 strobe length", last_len, HALF);
            read_bits(0, got);
            chk(got == VEC[v], "R5 nine bits read", got, VEC[v]);
            chk(data_out == 1'b1, "R5 idle after nine pulses", data_out, 1);
        end

        // R4: host pulse ends strobe early, and the pulse shifts once
        fork
            send_frame(9'h1A5);
            pulse_on_ready();
        join
        chk(last_len > 0 && last_len < HALF, "R4 early end by host_clk", last_len, HALF - 1);
        chk(data_out == 1'b0, "R5 bit1 after early pulse", data_out, 0);
        read_bits(1, got);
        chk(got[8:1] == 8'hD2, "R5 remaining bits", got[8:1], 8'hD2);

        // R8: one long pulse gives a single shift
        send_frame(9'h1A5);
        @(negedge clk);
        pulse(40);
        chk(data_out == 1'b0, "R8 long pulse single shift", data_out, 0);
        pulse(4);
        chk(data_out == 1'b1, "R8 next pulse shifts again", data_out, 1);

        // R7: overwrite before read
        send_frame(9'h1A5);
        send_frame(9'h15A);
        read_bits(0, got);
        chk(got == 9'h15A, "R7 overwrite", got, 9'h15A);

        // R3: short low glitch starts nothing
        ev = ready_events;
        @(negedge clk);
        rx_bit = 1'b0;
        repeat (HALF - 4) @(negedge clk);
        rx_bit = 1'b1;
        repeat (12 * C) @(negedge clk);
        chk(ready_events == ev, "R3 glitch rejected", ready_events, ev);
        chk(data_out == 1'b1, "R3 buffer untouched", data_out, 1);
        send_frame(9'h13C);
        chk(ready_events == ev + 1, "R3 real start accepted", ready_events, ev + 1);
        read_bits(0, got);
        chk(got == 9'h13C, "R3 word after glitch", got, 9'h13C);

        // R1: pass-through and host_clk ignored
        mode_sel = 1'b0;
        @(negedge clk);
        rx_bit = 1'b0;
        #1;
        chk(data_out == 1'b0, "R1 pass low", data_out, 0);
        rx_bit = 1'b1;
        #1;
        chk(data_out == 1'b1, "R1 pass high", data_out, 1);
        ev = ready_events;
        fork
            send_frame(9'h1A5);
            pulse_on_ready();
        join
        chk(ready_events == ev + 1 && last_len == HALF, "R1 host_clk ignored in mode 0", last_len, HALF);
        mode_sel = 1'b1;
        @(negedge clk);
        chk(data_out == 1'b1, "R1 buffer not shifted in mode 0", data_out, 1);

        // R6: power-down
        send_frame(9'h1A4);
        chk(data_out == 1'b0, "R6 word loaded before power-down", data_out, 0);
        ctl1 = 1'b0;
        @(negedge clk);
        chk(data_out == 1'b1 && ready_n == 1'b1, "R6 outputs idle", {data_out, ready_n}, 3);
        ev = ready_events;
        send_frame(9'h100);
        chk(ready_events == ev, "R6 reception stopped", ready_events, ev);
        ctl1 = 1'b1;
        repeat (2) @(negedge clk);
        chk(data_out == 1'b1, "R6 buffer cleared", data_out, 1);
        ctl2 = 1'b1;
        send_frame(9'h1C3);
        read_bits(0, got);
        chk(got == 9'h1C3, "R6 ctl2 high is normal mode 1", got, 9'h1C3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule